// File: doc/BRIEF.md
# UART Automatic Modem-Line Flow Control

This block adds hardware flow control to one UART channel. On the transmit side it decides whether the shifter may start the next character, based on an active-low clear input that comes from the far end. On the receive side it drives an active-low request output whose level depends on how full the receive FIFO is. A threshold pair with hysteresis keeps that output from toggling while the fill level sits between the two thresholds.

One select input picks the pin pair. When it is low, the CTS input gates transmit and RTS carries the automatic request. When it is high, DSR and DTR take those two roles instead. A request pin that is not under automatic control works as a general-purpose output and shows its manual bit. The surrounding UART supplies the FIFO fill level, the thresholds, the enables and the manual bits. It uses the transmit-permit output and the trigger-level interrupt.

Top module: `uart_autoflow`

## Requirements
- R1: During reset and until the first input change has propagated, `tx_permit` is 1, `trig_irq` is 0 and the internal throttle state is clear. With `pin_sel`=0 and both enables low, `rts_n` equals the inverse of `rts_man`.
- R2: `pin_sel`=0 uses `cts_n` as the transmit gate and `rts_n` as the automatic request pin. `pin_sel`=1 uses `dsr_n` and `dtr_n` instead. The clear input that is not selected has no effect on `tx_permit`, and the request pin that is not selected always equals the inverse of its manual bit.
- R3: With `auto_cts_en`=1 and `tx_busy`=0, `tx_permit` becomes the inverse of the selected clear input. Because of a two-stage synchronizer and an output register, it does so three rising edges after the input changes. While `tx_busy`=1, `tx_permit` holds its value, so a character in progress always completes.
- R4: With `auto_cts_en`=0 and `tx_busy`=0, `tx_permit` is 1 after the next rising edge, whatever the clear inputs are doing.
- R5: The throttle state is set on a rising edge where `fifo_level` >= `hi_thresh`. It is cleared on a rising edge where `fifo_level` is below the effective lower threshold. Otherwise it holds. While automatic control is active, the selected request pin is 1 exactly when the throttle state is set.
- R6: Automatic control is active only when `auto_rts_en`=1 and the manual bit of the selected pin is 1 (asserted). With `auto_rts_en`=1 and that manual bit 0, the pin stays at 1 at every fill level.
- R7: With `auto_rts_en`=0, both request pins are general-purpose outputs equal to the inverse of their manual bits.
- R8: `trig_irq` is a registered level. After a rising edge it is 1 exactly when, at that edge, `auto_rts_en`=1, `irq_en`=1 and `fifo_level` >= `trig_level`.
- R9: The effective lower threshold is `lo_thresh`, except when `lo_thresh` >= `hi_thresh`, in which case it is `hi_thresh`-1. The throttle state therefore never clears at a fill level of `hi_thresh`-1 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | LVL_W | Receive FIFO fill count |
| trig_level | input | LVL_W | Interrupt trigger level |
| hi_thresh | input | LVL_W | Upper hysteresis threshold |
| lo_thresh | input | LVL_W | Lower hysteresis threshold |
| auto_cts_en | input | 1 | Enables automatic transmit gating |
| auto_rts_en | input | 1 | Enables automatic request control |
| pin_sel | input | 1 | 0: CTS/RTS pair, 1: DSR/DTR pair |
| rts_man | input | 1 | Manual RTS bit, 1 = asserted (pin low) |
| dtr_man | input | 1 | Manual DTR bit, 1 = asserted (pin low) |
| irq_en | input | 1 | Trigger interrupt enable |
| tx_busy | input | 1 | Shifter is sending a character |
| cts_n | input | 1 | Asynchronous clear-to-send, active low |
| dsr_n | input | 1 | Asynchronous data-set-ready, active low |
| tx_permit | output | 1 | Shifter may start a new character |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| trig_irq | output | 1 | Trigger-level interrupt |

## Verification
The assertions assume that `hi_thresh` is at least 1. A zero upper threshold would leave the effective lower bound undefined, and the release check relies on it being positive. They also assume that `tx_busy` is driven synchronously. The stimulus sweeps `hi_thresh` only from 1 upward. It changes the thresholds, the level and the busy flag only on falling edges, and it moves the asynchronous clear inputs freely, because they pass through the synchronizer.

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] trig_level,
  input  logic [LVL_W-1:0] hi_thresh,
  input  logic [LVL_W-1:0] lo_thresh,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             pin_sel,
  input  logic             rts_man,
  input  logic             dtr_man,
  input  logic             irq_en,
  input  logic             tx_busy,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             tx_permit,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             trig_irq
);

  logic [1:0]       cts_q, dsr_q;
  logic             clear_n;
  logic [LVL_W-1:0] lo_eff;
  logic             throttle;
  logic             sel_man, auto_act, sel_req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q <= 2'b11;
      dsr_q <= 2'b11;
    end else begin
      cts_q <= {cts_q[0], cts_n};
      dsr_q <= {dsr_q[0], dsr_n};
    end
  end

  assign clear_n = pin_sel ? dsr_q[1] : cts_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_permit <= 1'b1;
    else if (!tx_busy)
      tx_permit <= !auto_cts_en || !clear_n;
  end

  assign lo_eff = (lo_thresh >= hi_thresh) ? hi_thresh - LVL_W'(1) : lo_thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      throttle <= 1'b0;
    else if (fifo_level >= hi_thresh)
      throttle <= 1'b1;
    else if (fifo_level < lo_eff)
      throttle <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trig_irq <= 1'b0;
    else
      trig_irq <= auto_rts_en && irq_en && (fifo_level >= trig_level);
  end

  assign sel_man   = pin_sel ? dtr_man : rts_man;
  assign auto_act  = auto_rts_en && sel_man;
  assign sel_req_n = auto_act ? throttle : !sel_man;
  assign rts_n     = pin_sel ? !rts_man : sel_req_n;
  assign dtr_n     = pin_sel ? sel_req_n : !dtr_man;

  assert_permit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy) |-> tx_permit == $past(tx_permit));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> $past(auto_rts_en && irq_en && fifo_level >= trig_level));

  assert_throttle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && $past(fifo_level >= hi_thresh)) |-> sel_req_n);

  assert_release_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(throttle) && !throttle) |->
      ({1'b0, $past(fifo_level)} + 1 < {1'b0, $past(hi_thresh)}));

  assert_unsel_manual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel ? (rts_n == !rts_man) : (dtr_n == !dtr_man));

endmodule

// File: tb/uart_autoflow_tb.sv
module uart_autoflow_tb_top;
  localparam int W = 5;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] fifo_level = 0, trig_level = 0, hi_thresh = 8, lo_thresh = 4;
  logic auto_cts_en = 0, auto_rts_en = 0, pin_sel = 0, rts_man = 0, dtr_man = 0;
  logic irq_en = 0, tx_busy = 0, cts_n = 1, dsr_n = 1;
  logic tx_permit, rts_n, dtr_n, trig_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_thr = 0;

  always #2.5 clk = ~clk;

  uart_autoflow #(.LVL_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .trig_level(trig_level),
    .hi_thresh(hi_thresh), .lo_thresh(lo_thresh), .auto_cts_en(auto_cts_en),
    .auto_rts_en(auto_rts_en), .pin_sel(pin_sel), .rts_man(rts_man), .dtr_man(dtr_man),
    .irq_en(irq_en), .tx_busy(tx_busy), .cts_n(cts_n), .dsr_n(dsr_n),
    .tx_permit(tx_permit), .rts_n(rts_n), .dtr_n(dtr_n), .trig_irq(trig_irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: inputs already set after a falling edge; model follows the rising edge
  task automatic step();
    int lo_e;
    @(posedge clk);
    lo_e = (int'(lo_thresh) >= int'(hi_thresh)) ? int'(hi_thresh) - 1 : int'(lo_thresh);
    if (int'(fifo_level) >= int'(hi_thresh)) m_thr = 1;
    else if (int'(fifo_level) < lo_e) m_thr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rts_man = 1;
    repeat (3) @(negedge clk);
    chk("R1 permit", tx_permit, 1);
    chk("R1 irq", trig_irq, 0);
    chk("R1 rts", rts_n, 0);
    rst_n = 1;
    step();

    // R4: gating off ignores the clear input
    cts_n = 1; repeat (4) step();
    chk("R4 permit with cts high", tx_permit, 1);

    // R3: auto gating, three-edge latency
    auto_cts_en = 1; step(); step(); step();
    chk("R3 halted", tx_permit, 0);
    cts_n = 0; step(); step();
    chk("R3 still halted at edge 2", tx_permit, 0);
    step();
    chk("R3 resumed at edge 3", tx_permit, 1);
    tx_busy = 1; cts_n = 1; repeat (5) step();
    chk("R3 hold while busy", tx_permit, 1);
    tx_busy = 0; step();
    chk("R3 halt after busy ends", tx_permit, 0);

    // R2: DSR selected, CTS ignored
    pin_sel = 1; dsr_n = 0; cts_n = 1; repeat (3) step();
    chk("R2 dsr gates permit", tx_permit, 1);
    dsr_n = 1; cts_n = 0; repeat (3) step();
    chk("R2 dsr high halts, cts ignored", tx_permit, 0);
    auto_cts_en = 0; step();
    chk("R4 permit restored", tx_permit, 1);

    // R7: general-purpose outputs
    pin_sel = 0; auto_rts_en = 0; fifo_level = 31; hi_thresh = 8;
    for (int m = 0; m < 4; m++) begin
      rts_man = m[0]; dtr_man = m[1]; step();
      chk("R7 rts manual", rts_n, !m[0]);
      chk("R7 dtr manual", dtr_n, !m[1]);
      chk("R8 irq off when auto off", trig_irq, 0);
    end

    // R6: manual bit not asserted blocks auto control
    auto_rts_en = 1; rts_man = 0;
    for (int l = 0; l < 32; l += 5) begin
      fifo_level = W'(l); step();
      chk("R6 rts stays high", rts_n, 1);
    end
    fifo_level = 0; step();

    // R5/R8/R9/R2 sweep over thresholds, both pin pairs
    rts_man = 1; dtr_man = 1; irq_en = 1;
    for (int ps = 0; ps < 2; ps++) begin
      pin_sel = ps[0];
      for (int h = 1; h < 16; h++) begin
        for (int lo = 0; lo < 16; lo++) begin
          hi_thresh = W'(h); lo_thresh = W'(lo); trig_level = W'(h);
          for (int k = 0; k < 36; k++) begin
            int lv;
            lv = (k < 18) ? k : 35 - k;
            fifo_level = W'(lv);
            irq_en = (k % 7) != 3;
            step();
            if (ps == 0) begin
              chk("R5 rts hysteresis", rts_n, m_thr);
              chk("R2 dtr manual", dtr_n, 0);
            end else begin
              chk("R5 dtr hysteresis", dtr_n, m_thr);
              chk("R2 rts manual", rts_n, 0);
            end
            chk("R8 irq level", trig_irq, int'(irq_en && lv >= h));
            if (lo >= h && k >= 18 && lv >= h - 1)
              chk("R9 no release near upper", int'(m_thr ? (ps == 0 ? rts_n : dtr_n) : 1), 1);
          end
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule